// File: doc/BRIEF.md
# Multi-Port Hardware Lock Flag Arbiter

This block holds a bank of single-bit lock flags that several processor cores share in order to guard critical sections. Each core has its own request port with two strobes: an acquire strobe (test-and-set) and a release strobe (clear). The core does not pass the lock number in the transfer payload. Instead, the block continuously watches a per-core selector byte and takes the lock number from its low bits.

An acquire returns a one-cycle result strobe together with a status byte. Bit 0 of that byte tells the core whether it now holds the lock. A release clears the selected flag, ignores whatever payload accompanies it and produces no result. No owner is recorded, so any core may clear any flag.

Requests from several ports in the same cycle are settled inside that cycle:
- Releases take effect before acquires.
- Acquires aimed at the same free flag go to the lowest-numbered port.
- Acquires aimed at different flags are handled independently.

Cores are expected to leave at least 8 clocks between a release and their next acquire. The block gives no guarantee of correct results when that gap is not kept.

Top module: `lock_flag_arbiter`

## Requirements
- R1: The bank holds NUM_LOCKS (default 64) independent flags addressed 0 to NUM_LOCKS-1. An acquire to any free index, including 0 and 63, succeeds.
- R2: A port's lock index is bits [5:0] of its 8-bit selector byte, sampled in the request cycle. Bits [7:6] of that byte have no effect.
- R3: Each acquire raises that port's status_vld for exactly one cycle, in the cycle after the request. The status byte has bit 0 = 1 on success, 0 on failure, and bits [7:1] = 0. With no acquire, status_vld is 0 and the status byte is 0.
- R4: An acquire to a clear flag sets it and reports success. A later acquire by another port to that flag reports failure.
- R5: An acquire to a flag that is already set leaves it set and reports failure, even when the requesting port set it.
- R6: A release clears the selected flag, so a later acquire to it succeeds. The release payload xfer_wdata has no effect, and a release raises no status_vld.
- R7: A release to a flag that is already clear leaves it clear, and a later acquire to it succeeds.
- R8: When several ports acquire the same free flag in one cycle, only the lowest-numbered port succeeds. All the others report failure.
- R9: Acquires from different ports to different indices in the same cycle are each served as if alone.
- R10: A release and an acquire to the same index in the same cycle act release-first. The acquirer succeeds and the flag ends up set.
- R11: Asserting rst_n low clears all flags and all result strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | NUM_PORTS | Per-port acquire (test-and-set) strobe |
| rel_req | input | NUM_PORTS | Per-port release strobe |
| side_sel | input | NUM_PORTS*8 | Per-port selector bytes; port p uses bits [p*8 +: 8], with the index in the low 6 bits |
| xfer_wdata | input | NUM_PORTS*8 | Per-port release payload bytes; ignored |
| status_vld | output | NUM_PORTS | Per-port one-cycle acquire result strobe |
| status_byte | output | NUM_PORTS*8 | Per-port acquire status byte; bit 0 set on success |

## Verification
The bench builds the block with its defaults: four ports and 64 flags. This makes the 6-bit index field, both end indices 0 and 63, and a four-way contention chain in which every port position is a possible winner all reachable. Four ports are enough to put acquires and releases to the same index into one cycle, and to mix same-index and different-index requests. Junk in the selector's upper bits and a changing release payload exercise the inputs the block must ignore.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;

  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned STATUS_OK_BIT = 0;

  function automatic logic [BYTE_W-1:0] pack_status(input logic won);
    logic [BYTE_W-1:0] s;
    s                = '0;
    s[STATUS_OK_BIT] = won;
    return s;
  endfunction

endpackage

// File: rtl/lock_port_decode.sv
module lock_port_decode #(
  parameter  int unsigned NUM_LOCKS = 64,
  localparam int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic                 acq_req,
  input  logic                 rel_req,
  input  logic [IDX_W-1:0]     sel_idx,
  output logic [NUM_LOCKS-1:0] acq_hot,
  output logic [NUM_LOCKS-1:0] rel_hot
);

  logic [NUM_LOCKS-1:0] idx_hot;

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_hot
    assign idx_hot[i] = (sel_idx == IDX_W'(i));
  end

  always_comb begin
    acq_hot = acq_req ? idx_hot : '0;
    rel_hot = rel_req ? idx_hot : '0;
  end

endmodule

// File: rtl/lock_grant_arbiter.sv
module lock_grant_arbiter #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned NUM_LOCKS = 64
) (
  input  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] acq_hot,
  input  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] rel_hot,
  input  logic [NUM_LOCKS-1:0]                flags,
  output logic [NUM_LOCKS-1:0]                rel_any,
  output logic [NUM_LOCKS-1:0]                acq_any,
  output logic [NUM_LOCKS-1:0]                set_vec,
  output logic [NUM_PORTS-1:0]                port_win
);

  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] grant;
  logic [NUM_LOCKS-1:0]                avail;

  // Release merge: a release in this cycle frees the flag for acquirers.
  always_comb begin
    rel_any = '0;
    acq_any = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      rel_any = rel_any | rel_hot[p];
      acq_any = acq_any | acq_hot[p];
    end
    avail = ~flags | rel_any;
  end

  // Fixed priority per flag: lowest port index wins.
  always_comb begin
    logic [NUM_LOCKS-1:0] taken;
    taken = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      grant[p] = acq_hot[p] & avail & ~taken;
      taken    = taken | acq_hot[p];
    end
  end

  always_comb begin
    set_vec = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      set_vec     = set_vec | grant[p];
      port_win[p] = |grant[p];
    end
  end

endmodule

// File: rtl/lock_flag_store.sv
module lock_flag_store #(
  parameter int unsigned NUM_LOCKS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LOCKS-1:0] set_vec,
  input  logic [NUM_LOCKS-1:0] clr_vec,
  output logic [NUM_LOCKS-1:0] flags
);

  logic [NUM_LOCKS-1:0] flags_d;
  logic                 flags_en;

  always_comb begin
    flags_en = |{set_vec, clr_vec};
    flags_d  = (flags & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (flags_en) begin
      flags <= flags_d;
    end
  end

endmodule

// File: rtl/lock_flag_arbiter.sv
module lock_flag_arbiter
  import lockarb_pkg::*;
#(
  parameter  int unsigned NUM_PORTS = 4,
  parameter  int unsigned NUM_LOCKS = 64,
  localparam int unsigned IDX_W     = $clog2(NUM_LOCKS),
  localparam int unsigned BUS_W     = NUM_PORTS * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] acq_req,
  input  logic [NUM_PORTS-1:0] rel_req,
  input  logic [BUS_W-1:0]     side_sel,
  input  logic [BUS_W-1:0]     xfer_wdata,
  output logic [NUM_PORTS-1:0] status_vld,
  output logic [BUS_W-1:0]     status_byte
);

  logic [NUM_PORTS-1:0][IDX_W-1:0]     port_idx;
  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] acq_hot;
  logic [NUM_PORTS-1:0][NUM_LOCKS-1:0] rel_hot;
  logic [NUM_LOCKS-1:0]                flags;
  logic [NUM_LOCKS-1:0]                rel_any;
  logic [NUM_LOCKS-1:0]                acq_any;
  logic [NUM_LOCKS-1:0]                set_vec;
  logic [NUM_PORTS-1:0]                port_win;
  logic [NUM_PORTS-1:0]                vld_d, vld_q;
  logic [NUM_PORTS-1:0]                win_d, win_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_idx[p] = side_sel[p*BYTE_W +: IDX_W];

    lock_port_decode #(
      .NUM_LOCKS (NUM_LOCKS)
    ) i_decode (
      .acq_req (acq_req[p]),
      .rel_req (rel_req[p]),
      .sel_idx (port_idx[p]),
      .acq_hot (acq_hot[p]),
      .rel_hot (rel_hot[p])
    );

    assign status_byte[p*BYTE_W +: BYTE_W] = pack_status(win_q[p]);
  end

  lock_grant_arbiter #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_LOCKS (NUM_LOCKS)
  ) i_arbiter (
    .acq_hot  (acq_hot),
    .rel_hot  (rel_hot),
    .flags    (flags),
    .rel_any  (rel_any),
    .acq_any  (acq_any),
    .set_vec  (set_vec),
    .port_win (port_win)
  );

  lock_flag_store #(
    .NUM_LOCKS (NUM_LOCKS)
  ) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (rel_any),
    .flags   (flags)
  );

  // Result path: one registered strobe per acquire.
  always_comb begin
    vld_d = acq_req;
    win_d = acq_req & port_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      win_q <= '0;
    end else begin
      vld_q <= vld_d;
      win_q <= win_d;
    end
  end

  assign status_vld = vld_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_INPUTS_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_req[p] || rel_req[p]) |->
        !$isunknown({side_sel[p*BYTE_W +: BYTE_W], xfer_wdata[p*BYTE_W +: BYTE_W]})); // R2
    AST_RESULT_FOLLOWS_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
      acq_req[p] |=> status_vld[p]); // R3
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !acq_req[p] |=> (!status_vld[p] && !status_byte[p*BYTE_W])); // R3
    AST_WIN_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_req[p] && port_win[p]) |=> flags[$past(port_idx[p])]); // R4
    AST_BUSY_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_req[p] && flags[port_idx[p]] && !rel_any[port_idx[p]]) |=>
        !status_byte[p*BYTE_W]); // R5
    AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_req[p] && !acq_any[port_idx[p]]) |=> !flags[$past(port_idx[p])]); // R6
    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      AST_HIGHER_PORT_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_req[p] && acq_req[q] && port_idx[p] == port_idx[q]) |=>
          !status_byte[q*BYTE_W]); // R8
    end
  end

endmodule

// File: tb/test_lock_flag_arbiter.sv
module test_lock_flag_arbiter;

  localparam int NP = 4;
  localparam int NL = 64;

  typedef struct packed {
    logic [3:0]      rq;
    logic [7:0]      ops;   // 2 bits per port: 01 acquire, 10 release
    logic [3:0][5:0] idx;
    logic [1:0]      junk;  // selector bits [7:6]
    logic [3:0]      ev;
    logic [3:0]      ew;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{rq:4'd1,  ops:8'h01, idx:{6'd0,6'd0,6'd0,6'd0},     junk:2'b00, ev:4'b0001, ew:4'b0001}, // R1 index 0
    '{rq:4'd4,  ops:8'h01, idx:{6'd0,6'd0,6'd0,6'd5},     junk:2'b00, ev:4'b0001, ew:4'b0001}, // R4 set
    '{rq:4'd4,  ops:8'h04, idx:{6'd0,6'd0,6'd5,6'd0},     junk:2'b00, ev:4'b0010, ew:4'b0000}, // R4 other port fails
    '{rq:4'd5,  ops:8'h01, idx:{6'd0,6'd0,6'd0,6'd5},     junk:2'b00, ev:4'b0001, ew:4'b0000}, // R5 holder retries
    '{rq:4'd6,  ops:8'h02, idx:{6'd0,6'd0,6'd0,6'd5},     junk:2'b00, ev:4'b0000, ew:4'b0000}, // R6 release, no strobe
    '{rq:4'd6,  ops:8'h04, idx:{6'd0,6'd0,6'd5,6'd0},     junk:2'b00, ev:4'b0010, ew:4'b0010}, // R6 freed
    '{rq:4'd7,  ops:8'h20, idx:{6'd0,6'd9,6'd0,6'd0},     junk:2'b00, ev:4'b0000, ew:4'b0000}, // R7 release clear flag
    '{rq:4'd7,  ops:8'h10, idx:{6'd0,6'd9,6'd0,6'd0},     junk:2'b00, ev:4'b0100, ew:4'b0100}, // R7 still free
    '{rq:4'd8,  ops:8'h54, idx:{6'd20,6'd20,6'd20,6'd0},  junk:2'b00, ev:4'b1110, ew:4'b0010}, // R8 three-way
    '{rq:4'd8,  ops:8'h55, idx:{6'd21,6'd21,6'd21,6'd21}, junk:2'b00, ev:4'b1111, ew:4'b0001}, // R8 four-way
    '{rq:4'd9,  ops:8'h55, idx:{6'd31,6'd30,6'd63,6'd40}, junk:2'b00, ev:4'b1111, ew:4'b1111}, // R9 and R1 index 63
    '{rq:4'd10, ops:8'h48, idx:{6'd63,6'd0,6'd63,6'd0},   junk:2'b00, ev:4'b1000, ew:4'b1000}, // R10 rel+acq
    '{rq:4'd10, ops:8'h04, idx:{6'd0,6'd0,6'd63,6'd0},    junk:2'b00, ev:4'b0010, ew:4'b0000}, // R10 flag set
    '{rq:4'd3,  ops:8'h00, idx:{6'd0,6'd0,6'd0,6'd0},     junk:2'b00, ev:4'b0000, ew:4'b0000}, // R3 idle
    '{rq:4'd2,  ops:8'h01, idx:{6'd0,6'd0,6'd0,6'd5},     junk:2'b11, ev:4'b0001, ew:4'b0000}, // R2 junk bits
    '{rq:4'd2,  ops:8'h02, idx:{6'd0,6'd0,6'd0,6'd5},     junk:2'b10, ev:4'b0000, ew:4'b0000}, // R2 release
    '{rq:4'd2,  ops:8'h10, idx:{6'd0,6'd5,6'd0,6'd0},     junk:2'b01, ev:4'b0100, ew:4'b0100}, // R2 freed
    '{rq:4'd9,  ops:8'h41, idx:{6'd2,6'd0,6'd0,6'd1},     junk:2'b00, ev:4'b1001, ew:4'b1001}  // R9 pair
  };

  logic            clk;
  logic            rst_n;
  logic [NP-1:0]   acq_req;
  logic [NP-1:0]   rel_req;
  logic [NP*8-1:0] side_sel;
  logic [NP*8-1:0] xfer_wdata;
  logic [NP-1:0]   status_vld;
  logic [NP*8-1:0] status_byte;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  lock_flag_arbiter #(.NUM_PORTS(NP), .NUM_LOCKS(NL)) i_lock_flag_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_req     (acq_req),
    .rel_req     (rel_req),
    .side_sel    (side_sel),
    .xfer_wdata  (xfer_wdata),
    .status_vld  (status_vld),
    .status_byte (status_byte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input int rq, input string what,
                       input logic [NP*8+NP-1:0] act, input logic [NP*8+NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    acq_req = '0;
    rel_req = '0;
    side_sel = '0;
  endtask

  function automatic logic [NP*8-1:0] exp_bytes(input logic [NP-1:0] w);
    logic [NP*8-1:0] b;
    b = '0;
    for (int p = 0; p < NP; p++) b[p*8] = w[p];
    return b;
  endfunction

  initial begin
    rst_n = 1'b0;
    xfer_wdata = '0;
    drive_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(11, "reset state", {status_vld, status_byte}, '0); // R11

    for (int v = 0; v < NV; v++) begin
      for (int p = 0; p < NP; p++) begin
        acq_req[p] = (VECS[v].ops[2*p +: 2] == 2'b01);
        rel_req[p] = (VECS[v].ops[2*p +: 2] == 2'b10);
        side_sel[p*8 +: 8] = {VECS[v].junk, VECS[v].idx[p]};
        xfer_wdata[p*8 +: 8] = 8'(v * 37 + p * 11) ^ 8'hA5; // R6 payload noise
      end
      @(negedge clk);
      drive_idle();
      check(int'(VECS[v].rq), $sformatf("vector %0d", v),
            {status_vld, status_byte}, {VECS[v].ev, exp_bytes(VECS[v].ew)});
    end

    // R3: strobe from the last vector is gone one cycle later
    @(negedge clk);
    check(3, "strobe single cycle", {status_vld, status_byte}, '0);

    // R11: reset in mid-run clears held flags 63, 5 and 21
    rst_n = 1'b0;
    @(negedge clk);
    check(11, "results cleared in reset", {status_vld, status_byte}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    acq_req = 4'b1011;
    side_sel = {8'd63, 8'd0, 8'd21, 8'd5};
    @(negedge clk);
    drive_idle();
    check(11, "flags free after reset", {status_vld, status_byte},
          {4'b1011, exp_bytes(4'b1011)});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule